// File: doc/BRIEF.md
# PCI Bus Cycle Monitor

A receive-only observer for a 32-bit PCI bus. Every rising edge of the PCI clock it samples the framing, ready, select and stop lines along with the multiplexed address/data lines, the command/byte-enable lines and the parity line. From these it produces one record per clock for a downstream capture store. Each record holds a set of per-clock classification flags, the command and address of the current transaction, the data on the bus in that clock, and a strobe that says whether the record should be captured.

The command and address are captured at the address phase and then kept for the rest of the transaction. Downstream triggers can therefore qualify data phases by address or command. Three static controls shape the record stream. One discards clocks in which either side is waiting. One discards bus-idle clocks. One enables checking of data parity.

All bus pins are inputs; the block has no output onto the bus. Bus control lines are active low at the ports: a value of 0 means asserted. Every output is registered. The record describing the bus as sampled at clock edge k is present on the outputs right after edge k.

Top module: `pci_cycle_mon`

## Requirements
- R1: On a clock with FRAME# asserted whose previous clock was idle (the address phase), `heldCmd` takes C/BE[3:0] and `heldAddr` takes AD. Both then keep those values until the next address phase.
- R2: The class flags follow the held command. `classIo` is set for 001x, `classMem` for 011x and `classCfg` for 101x. `dualAddr` is set for exactly 1101.
- R3: `isIdle` is set when FRAME# and IRDY# are both deasserted. `addrValid` is set on the address phase. `dataValid` is set when IRDY# and TRDY# are both asserted.
- R4: `waitTarget` is set when IRDY# is asserted and TRDY# is deasserted. `waitInit` is set when TRDY# is asserted, IRDY# is deasserted and FRAME# is asserted.
- R5: `retryFlag` is set on a clock after the address phase, inside a transaction that has not yet completed a data transfer, when STOP# and DEVSEL# are asserted and TRDY# is deasserted.
- R6: `targetAbort` is set on a clock after the address phase of an open transaction when STOP# is asserted and DEVSEL# is deasserted.
- R7: If DEVSEL# has not been asserted on any of clocks 1 to 5 after the address phase, `masterAbort` and `noDevice` are both set for one clock, on clock 5, while the transaction is still open.
- R8: With `noWaitEn` high, a clock with `waitTarget` or `waitInit` set has `smpValid` low. With it low, such clocks are not dropped for waiting.
- R9: With `noIdleEn` high, an idle clock has `smpValid` low. With it low, idle clocks are not dropped for being idle. All other clocks have `smpValid` high.
- R10: `parValid` is set one clock after an address or data phase. On that clock PAR is compared with the even parity (XOR) of the previous clock's AD and C/BE. A mismatch raises `parErr` for that one clock.
- R11: With `parChkEn` low, `parErr` stays low regardless of PAR.
- R12: `curData` equals AD as sampled at the same edge. During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | FRAME#, active low |
| irdyN | input | 1 | IRDY#, active low |
| trdyN | input | 1 | TRDY#, active low |
| devselN | input | 1 | DEVSEL#, active low |
| stopN | input | 1 | STOP#, active low |
| ad | input | 32 | Address/data lines |
| cbe | input | 4 | Command/byte-enable lines |
| par | input | 1 | Parity line |
| noWaitEn | input | 1 | Drop waiting clocks |
| noIdleEn | input | 1 | Drop idle clocks |
| parChkEn | input | 1 | Enable parity checking |
| smpValid | output | 1 | Record should be captured |
| isIdle | output | 1 | Bus idle clock |
| addrValid | output | 1 | Address phase |
| dataValid | output | 1 | Data transfer clock |
| waitTarget | output | 1 | Initiator ready, target not |
| waitInit | output | 1 | Target ready, initiator not |
| retryFlag | output | 1 | Retry termination |
| targetAbort | output | 1 | Target abort termination |
| masterAbort | output | 1 | No target responded in time |
| noDevice | output | 1 | No device selected |
| parValid | output | 1 | Parity checked this clock |
| parErr | output | 1 | Parity mismatch on previous phase |
| classIo | output | 1 | Held command is I/O |
| classMem | output | 1 | Held command is memory |
| classCfg | output | 1 | Held command is configuration |
| dualAddr | output | 1 | Held command is dual address |
| heldCmd | output | 4 | Command of current transaction |
| heldAddr | output | 32 | Address of current transaction |
| curData | output | 32 | AD in this clock |

## Verification
The hardest state to reach is the master-abort clock. It needs an address phase, then exactly five more clocks with FRAME# kept asserted and DEVSEL# never asserted, with no idle clock in between. Random bus toggling almost never produces this. A directed sequence therefore holds FRAME# and IRDY# for six clocks with DEVSEL# released. Random stimulus then checks that the counter neither fires twice nor fires after a late DEVSEL#. Retry on the first data phase and parity errors that are masked by the enable are also set up by directed sequences. These run before a long random run that is compared clock by clock against a bench model built from the requirements.

// File: rtl/pci_cycle_mon_pkg.sv
package pci_cycle_mon_pkg;

  // strobes from the control section to the datapath
  typedef struct packed {
    logic latchHdr;   // address phase: capture command and address
    logic phase;      // address or data phase: parity covers this clock
  } monStrb_t;

  // per-clock classification
  typedef struct packed {
    logic isIdle;
    logic addrValid;
    logic dataValid;
    logic waitTarget;
    logic waitInit;
    logic retryFlag;
    logic targetAbort;
    logic masterAbort;
    logic noDevice;
  } monFlags_t;

endpackage

// File: rtl/pci_cycle_mon_ctrl.sv
module pci_cycle_mon_ctrl
  import pci_cycle_mon_pkg::*;
#(
  parameter int ABORT_LIMIT = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameN,
  input  logic      irdyN,
  input  logic      trdyN,
  input  logic      devselN,
  input  logic      stopN,
  input  logic      noWaitEn,
  input  logic      noIdleEn,
  output monStrb_t  strb,
  output monFlags_t flags,
  output logic      smpValid
);
  localparam int CNT_W = $clog2(ABORT_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ABORT_LIMIT - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(ABORT_LIMIT);

  logic frameA, irdyA, trdyA, devselA, stopA;
  logic prevIdle, inXact, firstPend, devselSeen;
  logic [CNT_W-1:0] sinceAddr;
  monFlags_t nf;
  logic keep;

  assign frameA  = ~frameN;
  assign irdyA   = ~irdyN;
  assign trdyA   = ~trdyN;
  assign devselA = ~devselN;
  assign stopA   = ~stopN;

  always_comb begin
    nf = '0;
    nf.isIdle      = ~frameA & ~irdyA;
    nf.addrValid   = frameA & prevIdle;
    nf.dataValid   = irdyA & trdyA;
    nf.waitTarget  = irdyA & ~trdyA;
    nf.waitInit    = trdyA & ~irdyA & frameA;
    nf.retryFlag   = inXact & ~nf.addrValid & firstPend & stopA & devselA & ~trdyA;
    nf.targetAbort = inXact & ~nf.addrValid & stopA & ~devselA;
    nf.masterAbort = inXact & ~nf.addrValid & ~devselSeen & ~devselA &
                     (sinceAddr == CNT_LAST);
    nf.noDevice    = nf.masterAbort;
    keep = ~((noWaitEn & (nf.waitTarget | nf.waitInit)) | (noIdleEn & nf.isIdle));
    strb.latchHdr = nf.addrValid;
    strb.phase    = nf.addrValid | nf.dataValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIdle   <= 1'b1;
      inXact     <= 1'b0;
      firstPend  <= 1'b0;
      devselSeen <= 1'b0;
      sinceAddr  <= '0;
      flags      <= '0;
      smpValid   <= 1'b0;
    end else begin
      prevIdle <= nf.isIdle;
      flags    <= nf;
      smpValid <= keep;
      if (nf.addrValid)   inXact <= 1'b1;
      else if (nf.isIdle) inXact <= 1'b0;
      if (nf.addrValid)                        firstPend <= 1'b1;
      else if (nf.dataValid | nf.isIdle)       firstPend <= 1'b0;
      if (nf.addrValid)             devselSeen <= 1'b0;
      else if (inXact & devselA)    devselSeen <= 1'b1;
      if (nf.addrValid)                          sinceAddr <= '0;
      else if (inXact && sinceAddr < CNT_MAX)    sinceAddr <= sinceAddr + 1'b1;
    end
  end

  // R8
  nowait_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && (flags.waitTarget || flags.waitInit)) |-> !$past(noWaitEn));
  // R9
  noidle_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && flags.isIdle) |-> !$past(noIdleEn));
  // R7
  mabort_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.masterAbort |=> !flags.masterAbort);
  // R7
  mabort_nodev_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.masterAbort |-> (flags.noDevice && !flags.addrValid));
  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flags.isIdle, flags.dataValid, flags.waitTarget, flags.waitInit}));
endmodule

// File: rtl/pci_cycle_mon_dp.sv
module pci_cycle_mon_dp
  import pci_cycle_mon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] ad,
  input  logic [CBE_W-1:0]  cbe,
  input  logic              par,
  input  logic              parChkEn,
  input  monStrb_t          strb,
  output logic [CBE_W-1:0]  heldCmd,
  output logic [DATA_W-1:0] heldAddr,
  output logic [DATA_W-1:0] curData,
  output logic              parValid,
  output logic              parErr,
  output logic              classIo,
  output logic              classMem,
  output logic              classCfg,
  output logic              dualAddr
);
  localparam int CBE_W = DATA_W / 8;

  logic [CBE_W-1:0] cmdNext;
  logic prevPar, prevPhase;

  assign cmdNext = strb.latchHdr ? cbe : heldCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCmd   <= '0;
      heldAddr  <= '0;
      curData   <= '0;
      prevPar   <= 1'b0;
      prevPhase <= 1'b0;
      parValid  <= 1'b0;
      parErr    <= 1'b0;
      classIo   <= 1'b0;
      classMem  <= 1'b0;
      classCfg  <= 1'b0;
      dualAddr  <= 1'b0;
    end else begin
      if (strb.latchHdr) begin
        heldCmd  <= cbe;
        heldAddr <= ad;
      end
      curData   <= ad;
      prevPar   <= ^{ad, cbe};
      prevPhase <= strb.phase;
      parValid  <= prevPhase;
      parErr    <= parChkEn & prevPhase & (prevPar ^ par);
      classIo   <= (cmdNext[3:1] == 3'b001);
      classMem  <= (cmdNext[3:1] == 3'b011);
      classCfg  <= (cmdNext[3:1] == 3'b101);
      dualAddr  <= (cmdNext == 4'b1101);
    end
  end

  // R10
  parerr_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> parValid);
  // R11
  parerr_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> $past(parChkEn));
  // R1
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.latchHdr) |-> ($stable(heldCmd) && $stable(heldAddr)));
  // R2
  class_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({classIo, classMem, classCfg, dualAddr}));
endmodule

// File: rtl/pci_cycle_mon.sv
module pci_cycle_mon
  import pci_cycle_mon_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ABORT_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic              trdyN,
  input  logic              devselN,
  input  logic              stopN,
  input  logic [DATA_W-1:0] ad,
  input  logic [DATA_W/8-1:0] cbe,
  input  logic              par,
  input  logic              noWaitEn,
  input  logic              noIdleEn,
  input  logic              parChkEn,
  output logic              smpValid,
  output logic              isIdle,
  output logic              addrValid,
  output logic              dataValid,
  output logic              waitTarget,
  output logic              waitInit,
  output logic              retryFlag,
  output logic              targetAbort,
  output logic              masterAbort,
  output logic              noDevice,
  output logic              parValid,
  output logic              parErr,
  output logic              classIo,
  output logic              classMem,
  output logic              classCfg,
  output logic              dualAddr,
  output logic [DATA_W/8-1:0] heldCmd,
  output logic [DATA_W-1:0] heldAddr,
  output logic [DATA_W-1:0] curData
);
  monStrb_t  strb;
  monFlags_t flags;

  pci_cycle_mon_ctrl #(.ABORT_LIMIT(ABORT_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .devselN(devselN), .stopN(stopN), .noWaitEn(noWaitEn), .noIdleEn(noIdleEn),
    .strb(strb), .flags(flags), .smpValid(smpValid)
  );

  pci_cycle_mon_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ad(ad), .cbe(cbe), .par(par), .parChkEn(parChkEn),
    .strb(strb), .heldCmd(heldCmd), .heldAddr(heldAddr), .curData(curData),
    .parValid(parValid), .parErr(parErr), .classIo(classIo), .classMem(classMem),
    .classCfg(classCfg), .dualAddr(dualAddr)
  );

  assign isIdle      = flags.isIdle;
  assign addrValid   = flags.addrValid;
  assign dataValid   = flags.dataValid;
  assign waitTarget  = flags.waitTarget;
  assign waitInit    = flags.waitInit;
  assign retryFlag   = flags.retryFlag;
  assign targetAbort = flags.targetAbort;
  assign masterAbort = flags.masterAbort;
  assign noDevice    = flags.noDevice;
endmodule

// File: tb/pci_cycle_mon_tb.sv
`timescale 1ns/1ps
module pci_cycle_mon_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1, devselN = 1'b1, stopN = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic par = 1'b0;
  logic noWaitEn = 1'b0, noIdleEn = 1'b0, parChkEn = 1'b1;
  logic smpValid, isIdle, addrValid, dataValid, waitTarget, waitInit;
  logic retryFlag, targetAbort, masterAbort, noDevice, parValid, parErr;
  logic classIo, classMem, classCfg, dualAddr;
  logic [3:0] heldCmd;
  logic [31:0] heldAddr, curData;

  int nTests = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  pci_cycle_mon u_dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .devselN(devselN), .stopN(stopN), .ad(ad), .cbe(cbe), .par(par),
    .noWaitEn(noWaitEn), .noIdleEn(noIdleEn), .parChkEn(parChkEn),
    .smpValid(smpValid), .isIdle(isIdle), .addrValid(addrValid), .dataValid(dataValid),
    .waitTarget(waitTarget), .waitInit(waitInit), .retryFlag(retryFlag),
    .targetAbort(targetAbort), .masterAbort(masterAbort), .noDevice(noDevice),
    .parValid(parValid), .parErr(parErr), .classIo(classIo), .classMem(classMem),
    .classCfg(classCfg), .dualAddr(dualAddr), .heldCmd(heldCmd), .heldAddr(heldAddr),
    .curData(curData)
  );

  // model state, built from the requirements
  logic mPrevIdle = 1'b1, mInX = 1'b0, mFirst = 1'b0, mSeen = 1'b0;
  int   mSince = 0;
  logic mPrevPhase = 1'b0, mPrevPar = 1'b0;
  logic [3:0]  mCmd = '0;
  logic [31:0] mAddr = '0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] classOf(input logic [3:0] c);
    return {c[3:1] == 3'b001, c[3:1] == 3'b011, c[3:1] == 3'b101, c == 4'b1101};
  endfunction

  // one bus clock; control arguments are 1 = asserted
  task automatic step(input logic f, input logic i, input logic t, input logic d,
                      input logic s, input logic [31:0] a, input logic [3:0] c,
                      input logic badPar);
    logic eIdle, eAddr, eData, eWT, eWI, eRetry, eTAb, eMAb, eKeep, eParV, eParE;
    @(negedge clk);
    frameN = ~f; irdyN = ~i; trdyN = ~t; devselN = ~d; stopN = ~s;
    ad = a; cbe = c; par = (^{a, c}) ^ badPar;
    @(posedge clk);
    #1;
    eIdle  = ~f & ~i;
    eAddr  = f & mPrevIdle;
    eData  = i & t;
    eWT    = i & ~t;
    eWI    = t & ~i & f;
    eRetry = mInX & ~eAddr & mFirst & s & d & ~t;
    eTAb   = mInX & ~eAddr & s & ~d;
    eMAb   = mInX & ~eAddr & ~mSeen & ~d & (mSince == 4);
    eKeep  = ~((noWaitEn & (eWT | eWI)) | (noIdleEn & eIdle));
    eParV  = mPrevPhase;
    eParE  = parChkEn & mPrevPhase & (mPrevPar ^ par);
    if (eAddr) begin mCmd = c; mAddr = a; end
    chk({heldCmd, heldAddr} == {mCmd, mAddr}, "R1 held cmd/addr",
        {28'd0, heldCmd, heldAddr}, {28'd0, mCmd, mAddr});
    chk({classIo, classMem, classCfg, dualAddr} == classOf(mCmd), "R2 class flags",
        {classIo, classMem, classCfg, dualAddr}, classOf(mCmd));
    chk({isIdle, addrValid, dataValid} == {eIdle, eAddr, eData}, "R3 idle/addr/data",
        {isIdle, addrValid, dataValid}, {eIdle, eAddr, eData});
    chk({waitTarget, waitInit} == {eWT, eWI}, "R4 wait flags",
        {waitTarget, waitInit}, {eWT, eWI});
    chk(retryFlag == eRetry, "R5 retry", retryFlag, eRetry);
    chk(targetAbort == eTAb, "R6 target abort", targetAbort, eTAb);
    chk({masterAbort, noDevice} == {eMAb, eMAb}, "R7 master abort",
        {masterAbort, noDevice}, {eMAb, eMAb});
    chk(smpValid == eKeep, noWaitEn ? "R8 smpValid" : "R9 smpValid", smpValid, eKeep);
    chk({parValid, parErr} == {eParV, eParE}, parChkEn ? "R10 parity" : "R11 parity off",
        {parValid, parErr}, {eParV, eParE});
    chk(curData == a, "R12 curData", curData, a);
    // advance the model
    mPrevIdle = eIdle;
    if (eAddr) mInX = 1'b1; else if (eIdle) mInX = 1'b0;
    if (eAddr) mFirst = 1'b1; else if (eData | eIdle) mFirst = 1'b0;
    if (eAddr) mSeen = 1'b0; else if (mInX & d) mSeen = 1'b1;
    if (eAddr) mSince = 0; else if (mInX && mSince < 5) mSince++;
    mPrevPhase = eAddr | eData;
    mPrevPar   = ^{a, c};
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 32'h0, 4'h0, 0);
  endtask

  // short transaction: address, one target wait, two transfers
  task automatic xact(input logic [31:0] a, input logic [3:0] c);
    step(1, 0, 0, 0, 0, a, c, 0);
    step(1, 1, 0, 1, 0, 32'hA5A5_0001, 4'h0, 0);
    step(1, 0, 1, 1, 0, 32'hA5A5_0002, 4'h0, 0);
    step(1, 1, 1, 1, 0, 32'hA5A5_0003, 4'h0, 0);
    step(0, 1, 1, 1, 0, 32'hA5A5_0004, 4'h0, 0);
    idle(1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // reset state (R12)
    repeat (2) @(posedge clk);
    #1;
    chk({smpValid, isIdle, addrValid, heldCmd, heldAddr, curData, parErr} == '0,
        "R12 reset state", {smpValid, isIdle, heldCmd, parErr}, 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    // memory write, config read, I/O write, dual address
    xact(32'h1000_0040, 4'b0111);
    xact(32'h0000_0804, 4'b1010);
    xact(32'h0000_03F8, 4'b0011);
    xact(32'hFFFF_0000, 4'b1101);
    xact(32'h2000_0000, 4'b0100);
    // drop waits and idles
    noWaitEn = 1'b1;
    xact(32'h3000_0010, 4'b0110);
    noIdleEn = 1'b1;
    idle(3);
    xact(32'h3000_0020, 4'b1110);
    noWaitEn = 1'b0; noIdleEn = 1'b0;
    // master abort: no DEVSEL# for six clocks (R7)
    step(1, 0, 0, 0, 0, 32'h4000_0000, 4'b0110, 0);
    for (int k = 0; k < 6; k++) step(1, 1, 0, 0, 0, 32'h0, 4'h0, 0);
    step(0, 1, 0, 0, 0, 32'h0, 4'h0, 0);
    idle(1);
    // late DEVSEL# on clock 4 prevents the abort
    step(1, 0, 0, 0, 0, 32'h4000_0100, 4'b0110, 0);
    for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 0, 32'h0, 4'h0, 0);
    for (int k = 0; k < 3; k++) step(1, 1, 0, 1, 0, 32'h0, 4'h0, 0);
    step(0, 1, 1, 1, 0, 32'h0, 4'h0, 0);
    idle(1);
    // retry on first data phase (R5)
    step(1, 0, 0, 0, 0, 32'h5000_0000, 4'b0110, 0);
    step(1, 1, 0, 1, 1, 32'h0, 4'h0, 0);
    step(0, 1, 0, 1, 1, 32'h0, 4'h0, 0);
    idle(1);
    // target abort (R6)
    step(1, 0, 0, 0, 0, 32'h5000_0100, 4'b0111, 0);
    step(1, 1, 0, 1, 0, 32'h1, 4'h0, 0);
    step(1, 1, 0, 0, 1, 32'h2, 4'h0, 0);
    step(0, 1, 0, 0, 1, 32'h3, 4'h0, 0);
    idle(1);
    // parity error with checking on, then masked (R10, R11)
    step(1, 0, 0, 0, 0, 32'h6000_0000, 4'b0111, 0);
    step(1, 1, 1, 1, 0, 32'h1234_5678, 4'h0, 1);
    step(0, 1, 1, 1, 0, 32'h9ABC_DEF0, 4'h0, 1);
    idle(2);
    parChkEn = 1'b0;
    step(1, 0, 0, 0, 0, 32'h6000_0100, 4'b0111, 0);
    step(0, 1, 1, 1, 0, 32'h0F0F_0F0F, 4'h0, 1);
    idle(2);
    parChkEn = 1'b1;
    // random bus activity
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if (n % 97 == 0) begin
        noWaitEn = 1'($urandom); noIdleEn = 1'($urandom); parChkEn = 1'($urandom);
      end
      step(r[0] | r[1], r[2] | r[3], r[4], r[5] | r[6], (r[7] & r[4]) ? 1'b0 : r[7],
           $urandom, 4'($urandom), ($urandom % 8) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule